// File: doc/BRIEF.md
# Virtual Interruption Register Access Filter

This block sits beside a guest's instruction pipeline. It judges every move into or out of the guest's virtual interruption control registers. It keeps a shadow copy of those registers:

- status-word copy
- status
- instruction pointer
- faulting address
- translation word
- previous instruction address
- function state
- immediate
- hash address
- two instruction bundles

For each request, the block applies the virtualization mode, the guest's current privilege level, the virtual interruption-collection bit and two per-direction acceleration enables. From these it decides whether the access completes locally, raises one coded fault, or must be sent to the monitor.

A request is a single-cycle strobe. It carries:

- a register index
- a direction
- write data and its NaT bit
- for reads, the destination general register number and the current stacked-frame size

One cycle later the block presents a 3-bit result code and, for reads that complete locally, the register value. An accelerated write that completes updates the shadow bank on the same edge that registers the result. Every other access leaves the bank untouched.

Top module: `vcr_access_filter`

## Requirements
- R1: A request with virtualization mode clear returns code 0 (complete), leaves the shadow bank unchanged, and returns zero read data.
- R2: With virtualization mode set, a write whose write-acceleration enable is clear returns code 1 (intercept) and leaves the bank unchanged. A read whose read-acceleration enable is clear also returns code 1.
- R3: An accelerated write with no fault condition returns code 0 and stores the data. An accelerated read with no fault returns code 0 and that stored value. Register indices are 0 status copy, 1 status, 2 instruction pointer, 3 faulting address, 4 translation, 5 previous address, 6 function state, 7 immediate, 8 hash address, 9 and 10 bundles. All registers reset to zero.
- R4: An accelerated access returns code 2 (illegal operation) in any of these cases:
  - the interruption-collection bit is set;
  - for a read, the destination register is 0;
  - for a read, the destination register is stacked (32 or above) and (destination - 32) is not below the frame size;
  - for a read, the index is above 10.
- R5: An accelerated access returns code 3 (privileged operation) when the privilege level is nonzero.
- R6: An accelerated write with its NaT bit set returns code 4 (NaT consumption).
- R7: An accelerated write returns code 5 (reserved field) when the data has a one in a reserved bit, or when the index is above 10. The reserved bits are 63:45 of register 0, 63:17 of register 1 and 63:32 of register 6.
- R8: An accelerated write to register 3 returns code 6 (unimplemented address) unless bits 60:50 of the data are all zeros or all ones. Bits 63:61 are a free region field. Other registers never get code 6.
- R9: When several fault conditions hold, the code is the first of 2, 3, 4, 5, 6 in that order.
- R10: The result valid flag rises exactly one cycle after each request strobe and is low after reset and in every cycle not following a strobe.
- R11: A write returning any nonzero code leaves every shadow register unchanged, and any result other than an accelerated completed read carries zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = move to register, 0 = move from register |
| req_index | input | 4 | Shadow register index |
| req_wdata | input | 64 | Write data |
| req_nat | input | 1 | NaT bit of the write source |
| req_dest | input | 7 | Destination general register of a read |
| frame_size | input | 7 | Current stacked-frame size |
| vm_mode | input | 1 | Virtualization mode |
| vcpl | input | 2 | Virtual current privilege level |
| vic | input | 1 | Virtual interruption-collection bit |
| accel_wr_en | input | 1 | Write acceleration enable |
| accel_rd_en | input | 1 | Read acceleration enable |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_code | output | 3 | Result code 0 to 6 |
| res_rdata | output | 64 | Read data for completed accelerated reads |

## Verification
Some rules are checked by assertions on every cycle:
- the one-cycle result timing;
- the bypass code when virtualization is off;
- the intercept on unaccelerated writes;
- the top priority of the collection-bit fault;
- the bank never moving on a request that cannot commit;
- zero read data on non-completing results.

Other behaviour shows only through the scoreboard scenarios:
- the remaining fault codes and their ordering;
- the reserved-bit masks;
- the sign-extension test on the faulting address;
- stacked-frame destination checks;
- read-back proving that faulting, intercepted and bypassed writes left the registers intact.

// File: rtl/vcr_pkg.sv
// Package: shared result codes and default sizes for the virtual
// interruption register access filter.
package vcr_pkg;

    typedef enum logic [2:0] {
        RES_COMPLETE  = 3'd0,
        RES_INTERCEPT = 3'd1,
        RES_ILLEGAL   = 3'd2,
        RES_PRIV      = 3'd3,
        RES_NAT       = 3'd4,
        RES_RSVD      = 3'd5,
        RES_UNIMPL    = 3'd6
    } res_code_e;

    localparam int VCR_DATA_W    = 64;
    localparam int VCR_NUM_REGS  = 11;
    localparam int VCR_IDX_W     = 4;
    localparam int VCR_GR_W      = 7;
    localparam int VCR_FADDR_IDX = 3;

endpackage

// File: rtl/vcr_decide.sv
// vcr_decide: combinational judgement of one access.
// Produces the result code from the request and guest state.
// Assumes NUM_REGS <= 2**IDX_W and IMPL_VA_W <= DATA_W - REGION_W.
// Fault priority: illegal, privileged, NaT, reserved, unimplemented.
module vcr_decide
    import vcr_pkg::*;
#(
    parameter int DATA_W    = VCR_DATA_W,
    parameter int NUM_REGS  = VCR_NUM_REGS,
    parameter int IDX_W     = VCR_IDX_W,
    parameter int GR_W      = VCR_GR_W,
    parameter int FADDR_IDX = VCR_FADDR_IDX,
    parameter int IMPL_VA_W = 51,
    parameter int REGION_W  = 3,
    parameter logic [NUM_REGS-1:0][DATA_W-1:0] RSVD_MASK = '0
) (
    input  logic              is_write,
    input  logic [IDX_W-1:0]  index,
    input  logic [DATA_W-1:0] wdata,
    input  logic              nat,
    input  logic [GR_W-1:0]   dest,
    input  logic [GR_W-1:0]   frame_size,
    input  logic              vm_mode,
    input  logic [1:0]        vcpl,
    input  logic              vic,
    input  logic              accel_wr_en,
    input  logic              accel_rd_en,
    output res_code_e         code
);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_REGS - 1);
    localparam logic [IDX_W-1:0] FADDR_SEL = IDX_W'(FADDR_IDX);
    localparam logic [GR_W-1:0]  STACK_BASE = GR_W'(32);
    localparam int EXT_HI = DATA_W - REGION_W - 1;
    localparam int EXT_LO = IMPL_VA_W - 1;

    logic              idx_bad;
    logic [DATA_W-1:0] sel_mask;
    logic [GR_W-1:0]   stack_off;
    logic              out_of_frame;
    logic [EXT_HI-EXT_LO:0] ext_bits;
    logic              addr_bad;
    logic              f_illegal, f_priv, f_nat, f_rsvd, f_unimpl;

    // Pick the reserved-bit mask of the addressed register.
    always_comb begin
        sel_mask = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (index == IDX_W'(i)) sel_mask = RSVD_MASK[i];
        end
    end

    // Classify the read destination and the write address value.
    always_comb begin
        idx_bad      = index > LAST_IDX;
        stack_off    = dest - STACK_BASE;
        out_of_frame = (dest >= STACK_BASE) && (stack_off >= frame_size);
        ext_bits     = wdata[EXT_HI:EXT_LO];
        addr_bad     = !((ext_bits == '0) || (ext_bits == '1));
    end

    // Raw fault conditions, before priority.
    always_comb begin
        f_illegal = vic || (!is_write && ((dest == '0) || out_of_frame || idx_bad));
        f_priv    = vcpl != 2'd0;
        f_nat     = is_write && nat;
        f_rsvd    = is_write && (idx_bad || ((wdata & sel_mask) != '0));
        f_unimpl  = is_write && (index == FADDR_SEL) && addr_bad;
    end

    // Choose bypass, intercept, or the highest-priority fault.
    always_comb begin
        if (!vm_mode)                      code = RES_COMPLETE;
        else if (is_write && !accel_wr_en) code = RES_INTERCEPT;
        else if (!is_write && !accel_rd_en) code = RES_INTERCEPT;
        else if (f_illegal)                code = RES_ILLEGAL;
        else if (f_priv)                   code = RES_PRIV;
        else if (f_nat)                    code = RES_NAT;
        else if (f_rsvd)                   code = RES_RSVD;
        else if (f_unimpl)                 code = RES_UNIMPL;
        else                               code = RES_COMPLETE;
    end

endmodule

// File: rtl/vcr_shadow_bank.sv
// vcr_shadow_bank: the guest's shadow interruption registers.
// Holds one register per index and writes one at a time on wr_en.
// Assumes the caller raises wr_en only for a committed write.
// An index beyond the bank selects nothing.
module vcr_shadow_bank #(
    parameter int DATA_W   = 64,
    parameter int NUM_REGS = 11,
    parameter int IDX_W    = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    logic [NUM_REGS-1:0] sel;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Decode this register's write select.
        assign sel[g] = wr_en && (wr_idx == IDX_W'(g));

        // Clear on reset, load on a selected write.
        always_ff @(posedge clk) begin
            if (!rst_n)      regs[g] <= '0;
            else if (sel[g]) regs[g] <= wr_data;
        end
    end

    // R3
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R11
    bad_index_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx > LAST_IDX)) |=> $stable(regs));

endmodule

// File: rtl/vcr_access_filter.sv
// vcr_access_filter: top of the virtual interruption register filter.
// Judges each strobed access, commits accelerated writes to the shadow
// bank, and registers a 3-bit code plus read data one cycle later.
// Assumes one request per strobe cycle.
// Writes and reads are never issued in the same cycle.
module vcr_access_filter
    import vcr_pkg::*;
#(
    parameter int DATA_W    = VCR_DATA_W,
    parameter int NUM_REGS  = VCR_NUM_REGS,
    parameter int IDX_W     = VCR_IDX_W,
    parameter int GR_W      = VCR_GR_W,
    parameter int FADDR_IDX = VCR_FADDR_IDX,
    parameter int IMPL_VA_W = 51,
    parameter int REGION_W  = 3,
    parameter logic [NUM_REGS-1:0][DATA_W-1:0] RSVD_MASK = {
        64'h0, 64'h0, 64'h0, 64'h0,
        64'hFFFF_FFFF_0000_0000,
        64'h0, 64'h0, 64'h0, 64'h0,
        64'hFFFF_FFFF_FFFE_0000,
        64'hFFFF_E000_0000_0000 }
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_nat,
    input  logic [GR_W-1:0]   req_dest,
    input  logic [GR_W-1:0]   frame_size,
    input  logic              vm_mode,
    input  logic [1:0]        vcpl,
    input  logic              vic,
    input  logic              accel_wr_en,
    input  logic              accel_rd_en,
    output logic              res_valid,
    output logic [2:0]        res_code,
    output logic [DATA_W-1:0] res_rdata
);
    res_code_e                       code_d;
    logic                            commit;
    logic                            rd_hit;
    logic [DATA_W-1:0]               rd_val;
    logic [NUM_REGS-1:0][DATA_W-1:0] bank;

    vcr_decide #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .GR_W(GR_W),
        .FADDR_IDX(FADDR_IDX), .IMPL_VA_W(IMPL_VA_W), .REGION_W(REGION_W),
        .RSVD_MASK(RSVD_MASK)
    ) u_decide (
        .is_write(req_write), .index(req_index), .wdata(req_wdata),
        .nat(req_nat), .dest(req_dest), .frame_size(frame_size),
        .vm_mode(vm_mode), .vcpl(vcpl), .vic(vic),
        .accel_wr_en(accel_wr_en), .accel_rd_en(accel_rd_en),
        .code(code_d)
    );

    // Commit only accelerated writes that judged clean.
    assign commit = req_valid && req_write && vm_mode && (code_d == RES_COMPLETE);
    // Return data only for accelerated reads that judged clean.
    assign rd_hit = req_valid && !req_write && vm_mode && (code_d == RES_COMPLETE);

    vcr_shadow_bank #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_idx(req_index),
        .wr_data(req_wdata), .regs(bank)
    );

    // Read multiplexer over the shadow bank.
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (req_index == IDX_W'(i)) rd_val = bank[i];
        end
    end

    // Register the result one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_code  <= 3'd0;
            res_rdata <= '0;
        end else begin
            res_valid <= req_valid;
            res_code  <= req_valid ? code_d : RES_COMPLETE;
            res_rdata <= rd_hit ? rd_val : '0;
        end
    end

    // R10
    result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R10
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    // R1
    bypass_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !vm_mode) |=> (res_code == 3'd0));

    // R2
    write_intercept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vm_mode && req_write && !accel_wr_en) |=> (res_code == 3'd1));

    // R4
    collect_bit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vm_mode && vic && (req_write ? accel_wr_en : accel_rd_en))
        |=> (res_code == 3'd2));

    // R11
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && vm_mode && accel_wr_en) |=> $stable(bank));

    // R11
    zero_data_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_code != 3'd0)) |-> (res_rdata == '0));

endmodule

// File: tb/vcr_access_filter_tb.sv
// Scoreboard bench for vcr_access_filter.
module vcr_access_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_nat = 1'b0;
    logic [3:0]  req_index = '0;
    logic [63:0] req_wdata = '0;
    logic [6:0]  req_dest = '0, frame_size = '0;
    logic        vm_mode = 1'b0, vic = 1'b0, accel_wr_en = 1'b0, accel_rd_en = 1'b0;
    logic [1:0]  vcpl = '0;
    logic        res_valid;
    logic [2:0]  res_code;
    logic [63:0] res_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [2:0]  code;
        logic [63:0] data;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [63:0] mdl_bank [0:10];

    // Per-access context; reset to defaults by ctx_default.
    logic       c_vm, c_aw, c_ar, c_vic, c_nat;
    logic [1:0] c_cpl;
    int         c_dest, c_fs;

    always #10 clk = ~clk;

    vcr_access_filter u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_index(req_index), .req_wdata(req_wdata), .req_nat(req_nat),
        .req_dest(req_dest), .frame_size(frame_size), .vm_mode(vm_mode),
        .vcpl(vcpl), .vic(vic), .accel_wr_en(accel_wr_en),
        .accel_rd_en(accel_rd_en), .res_valid(res_valid), .res_code(res_code),
        .res_rdata(res_rdata)
    );

    task automatic ctx_default();
        c_vm = 1; c_aw = 1; c_ar = 1; c_vic = 0; c_nat = 0; c_cpl = 0;
        c_dest = 5; c_fs = 16;
    endtask

    function automatic logic [63:0] mask_of(int idx);
        case (idx)
            0: return 64'hFFFF_E000_0000_0000; // R7 bits 63:45
            1: return 64'hFFFF_FFFF_FFFE_0000; // R7 bits 63:17
            6: return 64'hFFFF_FFFF_0000_0000; // R7 bits 63:32
            default: return 64'h0;
        endcase
    endfunction

    // Expected code from the requirements.
    function automatic logic [2:0] model_code(logic wr, int idx, logic [63:0] wd);
        bit oof;
        bit ext_ok;
        if (!c_vm) return 3'd0;                       // R1
        if (wr && !c_aw) return 3'd1;                 // R2
        if (!wr && !c_ar) return 3'd1;                // R2
        oof = (c_dest >= 32) && ((c_dest - 32) >= c_fs);
        if (c_vic) return 3'd2;                       // R4
        if (!wr && (c_dest == 0 || oof || idx > 10)) return 3'd2;
        if (c_cpl != 0) return 3'd3;                  // R5
        if (!wr) return 3'd0;
        if (c_nat) return 3'd4;                       // R6
        if (idx > 10 || (wd & mask_of(idx)) != 0) return 3'd5; // R7
        ext_ok = (wd[60:50] == 11'h000) || (wd[60:50] == 11'h7FF);
        if (idx == 3 && !ext_ok) return 3'd6;         // R8
        return 3'd0;
    endfunction

    // Driver: apply one request, push the expected result.
    task automatic acc(logic wr, int idx, logic [63:0] wd, string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_index = 4'(idx); req_wdata = wd;
        req_nat = c_nat; req_dest = 7'(c_dest); frame_size = 7'(c_fs);
        vm_mode = c_vm; vcpl = c_cpl; vic = c_vic;
        accel_wr_en = c_aw; accel_rd_en = c_ar;
        e.code = model_code(wr, idx, wd);
        e.data = 64'h0;
        e.tag  = tag;
        if (!wr && c_vm && e.code == 3'd0) e.data = mdl_bank[idx];
        if (wr && c_vm && e.code == 3'd0) mdl_bank[idx] = wd;
        sb.push_back(e);
        @(posedge clk);
        #1 req_valid = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each result against the scoreboard head.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && res_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected result: actual valid=1 expected valid=0");
            end else begin
                e = sb.pop_front();
                if (res_code !== e.code || res_rdata !== e.data) begin
                    errors++;
                    $display("FAIL %s: actual code=%0d data=%h expected code=%0d data=%h",
                             e.tag, res_code, res_rdata, e.code, e.data);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 11; i++) mdl_bank[i] = 64'h0;
        ctx_default();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset: actual valid=%b expected 0", res_valid);
        end
        acc(0, 2, 0, "R3 reset value read");

        // R1 bypass with virtualization off
        c_vm = 0;
        acc(1, 2, 64'h1234_5678, "R1 bypass write");
        acc(0, 2, 0, "R1 bypass read");
        ctx_default();
        acc(0, 2, 0, "R1 bank untouched");

        // R2 intercepts
        c_aw = 0;
        acc(1, 2, 64'hAAAA, "R2 write intercept");
        ctx_default(); c_ar = 0;
        acc(0, 2, 0, "R2 read intercept");
        ctx_default();
        acc(0, 2, 0, "R2 bank untouched");

        // R3 accelerated completion
        acc(1, 2, 64'hDEAD_BEEF_0BAD_F00D, "R3 write ip");
        acc(0, 2, 0, "R3 read ip");
        acc(1, 9, 64'h0123_4567_89AB_CDEF, "R3 write bundle0");
        acc(1, 10, 64'hFEDC_BA98_7654_3210, "R3 write bundle1");
        acc(0, 9, 0, "R3 read bundle0");
        acc(0, 10, 0, "R3 read bundle1");

        // R4 illegal operation
        c_vic = 1;
        acc(1, 5, 64'h55, "R4 write with collection bit");
        acc(0, 5, 0, "R4 read with collection bit");
        ctx_default(); c_dest = 0;
        acc(0, 2, 0, "R4 read into reg 0");
        ctx_default(); c_dest = 40; c_fs = 8;
        acc(0, 2, 0, "R4 read out of frame");
        c_dest = 39;
        acc(0, 2, 0, "R4 read last in-frame");
        ctx_default();
        acc(0, 12, 0, "R4 read bad index");

        // R5 privileged operation
        c_cpl = 2'd3;
        acc(1, 7, 64'h77, "R5 write at cpl3");
        acc(0, 2, 0, "R5 read at cpl3");
        ctx_default();

        // R6 NaT consumption
        c_nat = 1;
        acc(1, 7, 64'h99, "R6 nat write");
        ctx_default();

        // R7 reserved fields
        acc(1, 1, 64'h0010_0000, "R7 status reserved bit");
        acc(1, 1, 64'h0001_FFFF, "R7 status legal value");
        acc(1, 0, 64'h0000_2000_0000_0000, "R7 copy reserved bit 45");
        acc(1, 6, 64'h1_0000_0000, "R7 fstate reserved bit 32");
        acc(1, 13, 64'h0, "R7 write bad index");

        // R8 unimplemented address
        acc(1, 3, 64'h0004_0000_0000_0000, "R8 unimpl address");
        acc(1, 3, 64'hE004_0000_0000_0000, "R8 unimpl with region");
        acc(1, 3, 64'hFFFC_0000_0000_1230, "R8 sign-extended address");
        acc(0, 3, 0, "R8 read fault address");
        acc(1, 4, 64'h0004_0000_0000_0000, "R8 other reg no addr check");

        // R9 priority
        c_vic = 1; c_cpl = 1; c_nat = 1;
        acc(1, 1, 64'h0010_0000, "R9 illegal over all");
        c_vic = 0;
        acc(1, 1, 64'h0010_0000, "R9 priv over nat");
        c_cpl = 0;
        acc(1, 1, 64'h0010_0000, "R9 nat over reserved");
        ctx_default();
        acc(1, 13, 64'h0004_0000_0000_0000, "R9 reserved over unimpl");

        // R11 faulting writes left bank intact
        acc(0, 1, 0, "R11 status after faults");
        acc(0, 7, 0, "R11 immediate after faults");
        acc(0, 0, 0, "R11 copy after faults");
        acc(0, 6, 0, "R11 fstate after faults");
        acc(0, 5, 0, "R11 prev addr after faults");

        // R10 no result in idle cycles
        idle(4);
        checks++;
        if (res_valid !== 1'b0 || sb.size() != 0) begin
            errors++;
            $display("FAIL R10 idle: actual valid=%b pending=%0d expected 0 0",
                     res_valid, sb.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule